// File: doc/BRIEF.md
# Main Clock Loss Detector with Backup Switchover

This block watches a fast main clock against a slow reference clock that never stops. The main clock is judged directly, before any division. Each reference period, a request token goes into the main-clock domain. The main clock has to echo the token back through a two-stage synchronizer. When the echo stays missing for `MISS_LIM` consecutive reference periods, the main clock is declared lost.

On a loss, the system clock output moves onto a backup oscillator through a glitch-free multiplexer. At the same moment a status bit and a sticky interrupt flag are set. The block stays on the backup clock until software clears the detector enable or a reset occurs.

Software reaches the block through a small register port in the reference-clock domain. Writes are single-cycle strobes and reads are combinational. There are two registers:

- Address 0 is control. Bit 0 is the detector enable. Bit 1 is the interrupt enable. Bit 2 is the backup-active status, which is read-only.
- Address 1 holds the loss flag in bit 0.

The controller is a four-state machine with these states:

- `ST_OFF`: detection is off.
- `ST_ARM`: a single settling cycle that issues a fresh token.
- `ST_WATCH`: misses are counted.
- `ST_BKUP`: running on the backup clock.

It has these transitions:

- OFF→ARM when the enable is 1.
- ARM→WATCH on the next cycle.
- WATCH→BKUP when the miss count reaches its limit with no echo.
- ARM, WATCH or BKUP→OFF whenever the enable is 0.

Top module: `clk_fail_det`

## Requirements
- R1: After reset, control (address 0) and flags (address 1) read 0, `irq` is 0, and `sys_clk` follows `main_clk`.
- R2: While control bit 0 is 0, a stopped main clock never sets the flag (flags bit 0) or the status (control bit 2).
- R3: With control bit 0 set, a running main clock never raises a failure, and neither does any pause of the main clock shorter than one reference period.
- R4: With detection on, if the main clock shows no rising edge for `MISS_LIM`+4 reference periods, control bit 2 and flags bit 0 are both 1 by the end of that gap.
- R5: `irq` is 1 exactly when flags bit 0 and control bit 1 are both 1.
- R6: Once control bit 2 is 1, `sys_clk` follows `bkup_clk`. The two sources never drive `sys_clk` at the same time.
- R7: Writing 1 to flags bit 0 clears the flag. Writing 0 leaves it unchanged.
- R8: While on the backup clock, the block stays there even if the main clock recovers. Writing control bit 0 to 0 clears control bit 2 and brings `sys_clk` back to `main_clk`.
- R9: Consider enabling detection with the main clock already stopped, where the write is captured on reference edge w. Control bit 2 is still 0 after edge w+`MISS_LIM`+1 and is 1 after edge w+`MISS_LIM`+2.
- R10: Writes to control bit 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| main_clk | input | 1 | Undivided main clock under watch |
| bkup_clk | input | 1 | Safe backup oscillator |
| ref_clk | input | 1 | Slow always-running reference; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 flags |
| reg_wdata | input | 3 | Write data |
| reg_rdata | output | 3 | Read data of the selected register |
| sys_clk | output | 1 | Selected system clock |
| irq | output | 1 | Interrupt request |

## Verification
Suppose the controller leaves `ST_WATCH` too early or counts too few misses. A short pause of the main clock would then set the status bit within a few reference periods. Suppose instead the token path or the miss counter stalls. Then the status bit would stay 0 through the `MISS_LIM`+4 period window. The arming cycle is pinned to a single reference edge, so an error in state order shows up as an off-by-one at the R9 sample points. A broken multiplexer enable shows within a handful of source-clock phases: `sys_clk` disagrees with the expected source when sampled mid-phase.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    localparam int REG_W    = 3;
    localparam int CTL_EN   = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_BK   = 2;
    localparam int FLG_FAIL = 0;
    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_FLG = 1'b1;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARM,
        ST_WATCH,
        ST_BKUP
    } cfd_state_e;
endpackage

// File: rtl/cfd_handshake.sv
// Token round trip: ref domain -> main domain -> ref domain.
module cfd_handshake #(
    parameter int SYNC_N = 2
) (
    input  logic main_clk,
    input  logic ref_clk,
    input  logic rst_n,
    input  logic restart,
    input  logic advance,
    output logic seen
);
    logic [SYNC_N-1:0] req_m;
    logic              ack_m;
    logic [SYNC_N-1:0] ack_r;
    logic              req_r;

    // main domain: echo the synchronized token
    always_ff @(posedge main_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_m <= '0;
            ack_m <= 1'b0;
        end else begin
            req_m <= {req_m[SYNC_N-2:0], req_r};
            ack_m <= req_m[SYNC_N-1];
        end
    end

    // reference domain: issue token and bring back the echo
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_r <= '0;
            req_r <= 1'b0;
        end else begin
            ack_r <= {ack_r[SYNC_N-2:0], ack_m};
            if (restart)
                req_r <= ~ack_r[SYNC_N-1];
            else if (advance)
                req_r <= ~req_r;
        end
    end

    assign seen = (ack_r[SYNC_N-1] == req_r);
endmodule

// File: rtl/cfd_fsm.sv
module cfd_fsm import cfd_pkg::*; #(
    parameter int MISS_LIM = 4
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic seen,
    output logic restart,
    output logic advance,
    output logic fail_set,
    output logic use_bkup
);
    localparam int CNT_W = $clog2(MISS_LIM + 1);
    localparam logic [CNT_W-1:0] LAST_MISS = CNT_W'(MISS_LIM - 1);

    cfd_state_e st, nxt;
    logic [CNT_W-1:0] miss_cnt;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF:   if (det_en) nxt = ST_ARM;
            ST_ARM:   nxt = det_en ? ST_WATCH : ST_OFF;
            ST_WATCH: begin
                if (!det_en)                             nxt = ST_OFF;
                else if (!seen && miss_cnt == LAST_MISS) nxt = ST_BKUP;
            end
            ST_BKUP:  if (!det_en) nxt = ST_OFF;
            default:  nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                          miss_cnt <= '0;
        else if (st != ST_WATCH || seen)     miss_cnt <= '0;
        else if (miss_cnt != LAST_MISS)      miss_cnt <= miss_cnt + 1'b1;
    end

    always_comb begin
        restart  = (st == ST_ARM);
        advance  = (st == ST_WATCH) && seen;
        fail_set = (st == ST_WATCH) && (nxt == ST_BKUP);
        use_bkup = (st == ST_BKUP);
    end
endmodule

// File: rtl/cfd_regs.sv
module cfd_regs import cfd_pkg::*; (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             fail_set,
    input  logic             use_bkup,
    output logic             det_en,
    output logic             irq_en,
    output logic             fail_flag,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    logic wr_ctl, wr_flg;
    assign wr_ctl = reg_wr && (reg_addr == ADDR_CTL);
    assign wr_flg = reg_wr && (reg_addr == ADDR_FLG);

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            det_en <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_ctl) begin
            det_en <= reg_wdata[CTL_EN];
            irq_en <= reg_wdata[CTL_IE];
        end
    end

    // set wins over a simultaneous write-one clear
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                              fail_flag <= 1'b0;
        else if (fail_set)                       fail_flag <= 1'b1;
        else if (wr_flg && reg_wdata[FLG_FAIL])  fail_flag <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTL) begin
            reg_rdata[CTL_EN] = det_en;
            reg_rdata[CTL_IE] = irq_en;
            reg_rdata[CTL_BK] = use_bkup;
        end else begin
            reg_rdata[FLG_FAIL] = fail_flag;
        end
    end

    assign irq = fail_flag && irq_en;
endmodule

// File: rtl/cfd_clk_mux.sv
module cfd_clk_mux #(
    parameter int SYNC_N = 2
) (
    input  logic main_clk,
    input  logic bkup_clk,
    input  logic rst_n,
    input  logic use_bkup,
    output logic m_en,
    output logic b_en,
    output logic sys_clk
);
    logic              m_clr;
    logic [SYNC_N-1:0] m_sync;
    logic [SYNC_N-1:0] b_sync;

    // a dead main clock cannot retire its own enable, so failure clears it
    assign m_clr = ~rst_n | use_bkup;

    always_ff @(posedge main_clk or posedge m_clr) begin
        if (m_clr) m_sync <= '0;
        else       m_sync <= {m_sync[SYNC_N-2:0], ~b_en};
    end

    always_ff @(negedge main_clk or posedge m_clr) begin
        if (m_clr) m_en <= 1'b0;
        else       m_en <= m_sync[SYNC_N-1];
    end

    always_ff @(posedge bkup_clk or negedge rst_n) begin
        if (!rst_n) b_sync <= '0;
        else        b_sync <= {b_sync[SYNC_N-2:0], use_bkup & ~m_en};
    end

    always_ff @(negedge bkup_clk or negedge rst_n) begin
        if (!rst_n) b_en <= 1'b0;
        else        b_en <= b_sync[SYNC_N-1];
    end

    assign sys_clk = (main_clk & m_en) | (bkup_clk & b_en);
endmodule

// File: rtl/clk_fail_det.sv
module clk_fail_det import cfd_pkg::*; #(
    parameter int MISS_LIM = 4,
    parameter int SYNC_N   = 2
) (
    input  logic             main_clk,
    input  logic             bkup_clk,
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sys_clk,
    output logic             irq
);
    logic seen, restart, advance, fail_set, use_bkup;
    logic det_en, irq_en, fail_flag;
    logic m_en, b_en;

    cfd_handshake #(.SYNC_N(SYNC_N)) u_hs (
        .main_clk (main_clk),
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .advance  (advance),
        .seen     (seen)
    );

    cfd_fsm #(.MISS_LIM(MISS_LIM)) u_fsm (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .det_en   (det_en),
        .seen     (seen),
        .restart  (restart),
        .advance  (advance),
        .fail_set (fail_set),
        .use_bkup (use_bkup)
    );

    cfd_regs u_regs (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .fail_set  (fail_set),
        .use_bkup  (use_bkup),
        .det_en    (det_en),
        .irq_en    (irq_en),
        .fail_flag (fail_flag),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    cfd_clk_mux #(.SYNC_N(SYNC_N)) u_mux (
        .main_clk (main_clk),
        .bkup_clk (bkup_clk),
        .rst_n    (rst_n),
        .use_bkup (use_bkup),
        .m_en     (m_en),
        .b_en     (b_en),
        .sys_clk  (sys_clk)
    );
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker import cfd_pkg::*; (
    input logic ref_clk,
    input logic rst_n,
    input logic det_en,
    input logic fail_flag,
    input logic use_bkup,
    input logic m_en,
    input logic b_en,
    input logic reg_wr,
    input logic reg_addr,
    input logic wr_bk,
    input logic wr_fail
);
    a_r4_flag_with_switch: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(use_bkup) |-> fail_flag);

    a_r8_leave_on_disable: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (use_bkup && !det_en) |=> !use_bkup);

    a_r9_quiet_after_enable: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(det_en) |=> !use_bkup);

    a_r7_zero_write_keeps: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (fail_flag && reg_wr && reg_addr == ADDR_FLG && !wr_fail) |=> fail_flag);

    a_r2_no_fail_disabled: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !det_en |=> !$rose(fail_flag));

    a_r10_status_ro: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTL && wr_bk && !det_en && !use_bkup) |=> !use_bkup);

    always_comb begin
        if (rst_n) begin
            a_r6_one_source: assert (!(m_en && b_en))
                else $error("both clock sources enabled");
        end
    end
endmodule

bind clk_fail_det cfd_checker u_chk (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .det_en    (det_en),
    .fail_flag (fail_flag),
    .use_bkup  (use_bkup),
    .m_en      (m_en),
    .b_en      (b_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wr_bk     (reg_wdata[cfd_pkg::CTL_BK]),
    .wr_fail   (reg_wdata[cfd_pkg::FLG_FAIL])
);

// File: tb/tb_clk_fail_det.sv
module tb_clk_fail_det;
    localparam int REF_PERIOD  = 400;
    localparam int MAIN_PERIOD = 10;
    localparam int BKUP_PERIOD = 16;
    localparam int LIM         = 4;

    logic main_clk = 1'b0, bkup_clk = 1'b0, ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_run = 1'b1, main_stuck = 1'b0;
    logic reg_wr = 1'b0, reg_addr = 1'b0;
    logic [2:0] reg_wdata = '0;
    logic [2:0] reg_rdata;
    logic sys_clk, irq;

    int n_chk = 0, n_fail = 0;

    clk_fail_det #(.MISS_LIM(LIM), .SYNC_N(2)) dut (
        .main_clk (main_clk), .bkup_clk (bkup_clk), .ref_clk (ref_clk),
        .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .sys_clk (sys_clk), .irq (irq)
    );

    always #(REF_PERIOD/2)  ref_clk  = ~ref_clk;
    always #(BKUP_PERIOD/2) bkup_clk = ~bkup_clk;
    always #(MAIN_PERIOD/2) main_clk = main_run ? ~main_clk : main_stuck;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [2:0] d);
        @(negedge ref_clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge ref_clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_ref(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    // count mid-phase disagreements between sys_clk and the chosen source
    task automatic follows(input bit bk, output int mism);
        mism = 0;
        for (int i = 0; i < 8; i++) begin
            if (bk) begin
                @(posedge bkup_clk); #(BKUP_PERIOD/4);
                if (sys_clk !== 1'b1) mism++;
                @(negedge bkup_clk); #(BKUP_PERIOD/4);
                if (sys_clk !== 1'b0) mism++;
            end else begin
                @(posedge main_clk); #(MAIN_PERIOD/4);
                if (sys_clk !== 1'b1) mism++;
                @(negedge main_clk); #(MAIN_PERIOD/4);
                if (sys_clk !== 1'b0) mism++;
            end
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(REF_PERIOD * 6000);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int v, m;
        wait_ref(3);
        rst_n = 1'b1;
        wait_ref(3);

        // R1 reset state
        rd(1'b0, v); chk("R1 ctrl", v, 0);
        rd(1'b1, v); chk("R1 flags", v, 0);
        chk("R1 irq", int'(irq), 0);
        follows(1'b0, m); chk("R1 sys follows main", m, 0);

        // R2 detection off with dead main
        main_stuck = 1'b0; main_run = 1'b0;
        wait_ref(LIM + 8);
        rd(1'b0, v); chk("R2 ctrl", v, 0);
        rd(1'b1, v); chk("R2 flags", v, 0);
        main_run = 1'b1;

        // R3 healthy clock and short pauses
        wr(1'b0, 3'b001);
        wait_ref(20);
        rd(1'b0, v); chk("R3 ctrl healthy", v, 1);
        rd(1'b1, v); chk("R3 flags healthy", v, 0);
        follows(1'b0, m); chk("R3 sys follows main", m, 0);
        for (int lvl = 0; lvl < 2; lvl++) begin
            for (int tenth = 3; tenth <= 9; tenth += 3) begin
                main_stuck = lvl[0]; main_run = 1'b0;
                #(REF_PERIOD * tenth / 10);
                main_run = 1'b1;
                wait_ref(12);
                rd(1'b0, v); chk("R3 ctrl after short pause", v, 1);
                rd(1'b1, v); chk("R3 flags after short pause", v, 0);
            end
        end

        // R9 arming cycle timing with main already dead
        main_stuck = 1'b0; main_run = 1'b0;
        wr(1'b0, 3'b000);
        wait_ref(3);
        wr(1'b0, 3'b001);
        wait_ref(LIM + 1);
        rd(1'b0, v); chk("R9 ctrl before limit", v, 1);
        wait_ref(1);
        rd(1'b0, v); chk("R9 ctrl at limit", v, 5);
        rd(1'b1, v); chk("R4 flag set", v, 1);
        chk("R5 irq masked", int'(irq), 0);
        follows(1'b1, m); chk("R6 sys follows backup", m, 0);

        // R7 write-one-to-clear, R5 enable, R10 status read-only
        wr(1'b1, 3'b000);
        rd(1'b1, v); chk("R7 zero write keeps flag", v, 1);
        wr(1'b0, 3'b011);
        rd(1'b0, v); chk("R10 ctrl status kept", v, 7);
        chk("R5 irq raised", int'(irq), 1);
        wr(1'b1, 3'b001);
        rd(1'b1, v); chk("R7 one clears flag", v, 0);
        chk("R5 irq dropped", int'(irq), 0);

        // R8 sticky backup, then release
        main_run = 1'b1;
        wait_ref(20);
        rd(1'b0, v); chk("R8 stays on backup", v, 7);
        follows(1'b1, m); chk("R8 sys still backup", m, 0);
        wr(1'b0, 3'b000);
        wait_ref(2);
        rd(1'b0, v); chk("R8 status cleared", v, 0);
        follows(1'b0, m); chk("R8 sys back to main", m, 0);

        // R10 status write ignored
        wr(1'b0, 3'b100);
        wait_ref(2);
        rd(1'b0, v); chk("R10 status write ignored", v, 0);

        // R4/R5/R6 sweep: stuck level x interrupt enable
        for (int lvl = 0; lvl < 2; lvl++) begin
            for (int ie = 0; ie < 2; ie++) begin
                wr(1'b0, {1'b0, ie[0], 1'b1});
                wait_ref(12);
                rd(1'b0, v); chk("R3 ctrl before stop", v, 1 + 2 * ie);
                main_stuck = lvl[0]; main_run = 1'b0;
                wait_ref(LIM + 4);
                rd(1'b0, v); chk("R4 status after gap", v, 5 + 2 * ie);
                rd(1'b1, v); chk("R4 flag after gap", v, 1);
                chk("R5 irq follows enable", int'(irq), ie);
                follows(1'b1, m); chk("R6 sys on backup", m, 0);
                main_run = 1'b1;
                wr(1'b0, 3'b000);
                wait_ref(3);
                follows(1'b0, m); chk("R8 sys restored", m, 0);
                wr(1'b1, 3'b001);
                rd(1'b1, v); chk("R7 flag cleared", v, 0);
            end
        end

        summary();
        $finish;
    end
endmodule